// File: doc/BRIEF.md
# Shared SRAM Port Multiplexer

This block lets a display fetch engine and a processor share one asynchronous SRAM. Each side owns a strobe, and the two strobes are never active together. The SRAM address is formed as a bitwise AND-OR. The display address is gated by the display strobe, the processor address is gated by the processor strobe, and the two gated words are ORed. When no strobe is active, the address bus rests at all zeros.

A processor write (processor strobe and write both high) asserts the SRAM write enable. The same write drives the processor's write word onto the SRAM data bus. That bus is bidirectional and is modelled as separate out, output-enable and in signals; outside a write the bus is released.

Read data from the SRAM goes to two separate capture registers. The processor register loads only when the processor is reading, its strobe is high and the clock phase input is high. It then keeps that word until the next qualified read, so the processor can pick it up at any later time. The display register loads a full data word while the display strobe is active and the slot index reads slot 0, the first of four pixel slots.

Top module: `sram_share_mux`

## Requirements
- R1: While only the display strobe `lcdStrobe` is high, `ramAddr` equals `lcdAddr`; while only the processor strobe `cpuStrobe` is high, `ramAddr` equals `cpuAddr`. The address path is combinational.
- R2: `lcdStrobe` and `cpuStrobe` are never high in the same cycle. If they were, `ramAddr` would be the bitwise OR of both addresses.
- R3: While neither strobe is high, `ramAddr` is all zeros.
- R4: `ramWe` (active high) is 1 exactly when `cpuStrobe` and `cpuWr` are both 1.
- R5: `ramOe` equals `ramWe`. While `ramOe` is 1, `ramDout` equals `cpuWrData`; while `ramOe` is 0, `ramDout` is all zeros.
- R6: At a rising clock edge where `cpuRd`, `cpuStrobe` and `clkPhase` are all 1, `cpuRdData` loads `ramDin`. The new value is visible after that edge.
- R7: At any other rising edge, `cpuRdData` holds its value. This covers a low clock phase, a low strobe and a missing read.
- R8: At a rising edge where `lcdStrobe` is 1 and `lcdSlot` equals 0 (slot T0), `lcdRdData` loads `ramDin`.
- R9: At any other rising edge, `lcdRdData` holds its value. This includes slots 1 to 3 and a low `lcdStrobe`.
- R10: While `rstN` is low, `cpuRdData` and `lcdRdData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture registers |
| rstN | input | 1 | Active-low synchronous reset |
| lcdAddr | input | ADDR_W (17) | Display read address |
| lcdStrobe | input | 1 | Display owns the SRAM |
| lcdSlot | input | 2 | Pixel slot index; 0 is slot T0 |
| cpuAddr | input | ADDR_W (17) | Processor address |
| cpuWrData | input | DATA_W (32) | Processor write word |
| cpuRd | input | 1 | Processor read request |
| cpuWr | input | 1 | Processor write request |
| cpuStrobe | input | 1 | Processor owns the SRAM |
| clkPhase | input | 1 | Clock phase qualifying processor capture |
| ramAddr | output | ADDR_W (17) | SRAM address |
| ramWe | output | 1 | SRAM write enable, active high |
| ramDout | output | DATA_W (32) | Word driven onto the SRAM data bus |
| ramOe | output | 1 | Drive enable for the SRAM data bus |
| ramDin | input | DATA_W (32) | Word read from the SRAM data bus |
| cpuRdData | output | DATA_W (32) | Captured processor read word |
| lcdRdData | output | DATA_W (32) | Captured display read word |

## Verification
The bench alternates random ownership with directed cases, each aimed at a specific fault:
- An idle bus with random addresses present: a design that passed an ungated address through would show a non-zero idle address.
- A processor read with the clock phase low: a design that skipped the phase qualifier would capture a word it should not.
- A display strobe in slots 1 to 3: a design that captured in every slot would overwrite the display word with later data.
- A processor strobe with both read and write raised: if the write enable or bus drive were tied to the wrong signal, the bus would show the wrong drive state.
- All-ones addresses and write words: these expose a truncated or misrouted bit.

// File: rtl/sram_share_pkg.sv
package sram_share_pkg;
  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic lcdSel;     // gate display address onto the bus
    logic cpuSel;     // gate processor address onto the bus
    logic writeEn;    // processor write cycle
    logic cpuCapture; // load processor read register
    logic lcdCapture; // load display read register
  } ctrlStrobes_t;
endpackage

// File: rtl/sram_share_ctrl.sv
module sram_share_ctrl
  import sram_share_pkg::*;
#(
  parameter int SLOT_W       = 2,
  parameter int CAPTURE_SLOT = 0
) (
  input  logic              lcdStrobe,
  input  logic [SLOT_W-1:0] lcdSlot,
  input  logic              cpuStrobe,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic              clkPhase,
  output ctrlStrobes_t      strobes
);
  localparam logic [SLOT_W-1:0] CAP_IDX = SLOT_W'(CAPTURE_SLOT);

  always_comb begin
    strobes.lcdSel     = lcdStrobe;
    strobes.cpuSel     = cpuStrobe;
    strobes.writeEn    = cpuStrobe & cpuWr;
    strobes.cpuCapture = cpuStrobe & cpuRd & clkPhase;
    strobes.lcdCapture = lcdStrobe & (lcdSlot == CAP_IDX);
  end
endmodule

// File: rtl/sram_share_datapath.sv
module sram_share_datapath
  import sram_share_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] lcdAddr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] ramDin,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramOe,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] lcdRdData
);
  // AND-OR address selection, one gate pair per bit
  for (genvar b = 0; b < ADDR_W; b++) begin : g_addrBit
    assign ramAddr[b] = (lcdAddr[b] & strobes.lcdSel) | (cpuAddr[b] & strobes.cpuSel);
  end

  // Write drive: the bus is driven only during a processor write
  assign ramWe   = strobes.writeEn;
  assign ramOe   = strobes.writeEn;
  assign ramDout = cpuWrData & {DATA_W{strobes.writeEn}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdData <= '0;
      lcdRdData <= '0;
    end else begin
      if (strobes.cpuCapture) cpuRdData <= ramDin;
      if (strobes.lcdCapture) lcdRdData <= ramDin;
    end
  end
endmodule

// File: rtl/sram_share_mux.sv
module sram_share_mux
  import sram_share_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 32,
  parameter int SLOT_W       = 2,
  parameter int CAPTURE_SLOT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lcdAddr,
  input  logic              lcdStrobe,
  input  logic [SLOT_W-1:0] lcdSlot,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic              cpuStrobe,
  input  logic              clkPhase,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramOe,
  input  logic [DATA_W-1:0] ramDin,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] lcdRdData
);
  ctrlStrobes_t strobes;

  sram_share_ctrl #(.SLOT_W(SLOT_W), .CAPTURE_SLOT(CAPTURE_SLOT)) u_ctrl (
    .lcdStrobe(lcdStrobe), .lcdSlot(lcdSlot), .cpuStrobe(cpuStrobe),
    .cpuRd(cpuRd), .cpuWr(cpuWr), .clkPhase(clkPhase), .strobes(strobes)
  );

  sram_share_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lcdAddr(lcdAddr), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .ramDin(ramDin),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramDout(ramDout), .ramOe(ramOe),
    .cpuRdData(cpuRdData), .lcdRdData(lcdRdData)
  );
endmodule

// File: rtl/sram_share_checker.sv
module sram_share_checker #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] lcdAddr,
  input logic              lcdStrobe,
  input logic [SLOT_W-1:0] lcdSlot,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuWrData,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic              cpuStrobe,
  input logic              clkPhase,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramWe,
  input logic [DATA_W-1:0] ramDout,
  input logic              ramOe,
  input logic [DATA_W-1:0] ramDin,
  input logic [DATA_W-1:0] cpuRdData,
  input logic [DATA_W-1:0] lcdRdData
);
  assert_lcd_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lcdStrobe && !cpuStrobe) |-> ramAddr == lcdAddr);
  assert_cpu_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStrobe && !lcdStrobe) |-> ramAddr == cpuAddr);
  assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(lcdStrobe && cpuStrobe));
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdStrobe && !cpuStrobe) |-> ramAddr == '0);
  assert_write_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe == (cpuStrobe && cpuWr));
  assert_bus_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    ramOe |-> (ramWe && ramDout == cpuWrData));
  assert_bus_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ramOe |-> (!ramWe && ramDout == '0));
  assert_cpu_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuStrobe && clkPhase) |=> cpuRdData == $past(ramDin));
  assert_cpu_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuRd && cpuStrobe && clkPhase) |=> $stable(cpuRdData));
  assert_lcd_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lcdStrobe && lcdSlot == '0) |=> lcdRdData == $past(ramDin));
  assert_lcd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(lcdStrobe && lcdSlot == '0) |=> $stable(lcdRdData));
  assert_reset_clear_R10: assert property (@(posedge clk)
    !rstN |=> (cpuRdData == '0 && lcdRdData == '0));
endmodule

bind sram_share_mux sram_share_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rstN(rstN), .lcdAddr(lcdAddr), .lcdStrobe(lcdStrobe), .lcdSlot(lcdSlot),
  .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .cpuStrobe(cpuStrobe), .clkPhase(clkPhase), .ramAddr(ramAddr), .ramWe(ramWe),
  .ramDout(ramDout), .ramOe(ramOe), .ramDin(ramDin), .cpuRdData(cpuRdData),
  .lcdRdData(lcdRdData)
);

// File: tb/sram_share_mux_test.sv
module sram_share_mux_test;
  localparam int AW = 17;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] lcdAddr = '0, cpuAddr = '0;
  logic lcdStrobe = 1'b0, cpuStrobe = 1'b0, cpuRd = 1'b0, cpuWr = 1'b0, clkPhase = 1'b0;
  logic [1:0] lcdSlot = '0;
  logic [DW-1:0] cpuWrData = '0, ramDin = '0;
  logic [AW-1:0] ramAddr;
  logic ramWe, ramOe;
  logic [DW-1:0] ramDout, cpuRdData, lcdRdData;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] expCpu = '0, expLcd = '0;

  always #4 clk = ~clk; // 125 MHz

  sram_share_mux uut (
    .clk(clk), .rstN(rstN), .lcdAddr(lcdAddr), .lcdStrobe(lcdStrobe), .lcdSlot(lcdSlot),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuStrobe(cpuStrobe), .clkPhase(clkPhase), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramDout(ramDout), .ramOe(ramOe), .ramDin(ramDin), .cpuRdData(cpuRdData),
    .lcdRdData(lcdRdData)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] modelAddr(logic ls, logic cs, logic [AW-1:0] la, logic [AW-1:0] ca);
    return (ls ? la : '0) | (cs ? ca : '0);
  endfunction

  // Drive one cycle (caller is at a negedge), check combinational outputs,
  // update the register model at the posedge, then check registers at the next negedge.
  task automatic cycle(input logic ls, input logic cs, input logic rd, input logic wr,
                       input logic ph, input logic [1:0] slot,
                       input logic [AW-1:0] la, input logic [AW-1:0] ca,
                       input logic [DW-1:0] wd, input logic [DW-1:0] din);
    lcdStrobe = ls; cpuStrobe = cs; cpuRd = rd; cpuWr = wr; clkPhase = ph;
    lcdSlot = slot; lcdAddr = la; cpuAddr = ca; cpuWrData = wd; ramDin = din;
    #1;
    if (ls) chk("R1 display addr", 64'(ramAddr), 64'(modelAddr(ls, cs, la, ca)));
    else if (cs) chk("R1 cpu addr", 64'(ramAddr), 64'(modelAddr(ls, cs, la, ca)));
    else chk("R3 idle addr", 64'(ramAddr), 64'(0));
    chk("R4 write enable", 64'(ramWe), 64'(cs && wr));
    chk("R5 bus enable", 64'(ramOe), 64'(cs && wr));
    chk("R5 bus data", 64'(ramDout), (cs && wr) ? 64'(wd) : 64'(0));
    @(posedge clk);
    if (cs && rd && ph) expCpu = din;
    if (ls && slot == 2'd0) expLcd = din;
    @(negedge clk);
    if (cs && rd && ph) chk("R6 cpu capture", 64'(cpuRdData), 64'(expCpu));
    else chk("R7 cpu hold", 64'(cpuRdData), 64'(expCpu));
    if (ls && slot == 2'd0) chk("R8 display capture", 64'(lcdRdData), 64'(expLcd));
    else chk("R9 display hold", 64'(lcdRdData), 64'(expLcd));
  endtask

  initial begin : watchdog
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 cpu reset", 64'(cpuRdData), 64'(0));
    chk("R10 display reset", 64'(lcdRdData), 64'(0));
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    cycle(0, 0, 1, 1, 1, 0, '1, '1, '1, 32'h1111_1111);                 // R3 idle with ones on inputs
    cycle(1, 0, 0, 0, 0, 0, '1, '0, '0, 32'hA5A5_5A5A);                 // R8 slot T0 capture, all-ones addr
    cycle(1, 0, 0, 0, 0, 2'd1, 17'h0_1234, '0, '0, 32'hDEAD_BEEF);      // R9 slot 1 ignored
    cycle(1, 0, 0, 0, 0, 2'd3, 17'h0_0F0F, '0, '0, 32'hCAFE_F00D);      // R9 slot 3 ignored
    cycle(0, 1, 1, 0, 1, 0, '0, '1, '0, 32'h1357_9BDF);                 // R6 qualified read
    cycle(0, 1, 1, 0, 0, 0, '0, 17'h0_00AA, '0, 32'h0BAD_0BAD);         // R7 phase low ignored
    cycle(0, 0, 1, 0, 1, 0, '0, 17'h0_00AA, '0, 32'h7777_7777);         // R7 strobe low ignored
    cycle(0, 1, 0, 1, 1, 0, '0, 17'h1_5555, 32'hFFFF_FFFF, 32'h2222_2222); // R4/R5 write, R7 no read
    cycle(0, 1, 1, 1, 1, 0, '0, 17'h0_AAAA, 32'h8000_0001, 32'h3333_3333); // write and read together

    // Constrained random: at most one strobe per cycle
    for (int i = 0; i < 400; i++) begin
      int mode = int'($urandom % 3);
      cycle(mode == 1, mode == 2, 1'($urandom), 1'($urandom), 1'($urandom),
            2'($urandom), AW'($urandom), AW'($urandom), $urandom, $urandom);
    end

    // Reset mid-run clears both registers
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 cpu reset again", 64'(cpuRdData), 64'(0));
    chk("R10 display reset again", 64'(lcdRdData), 64'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule